// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit sits beside the fetch stage of a 32-bit processor with one architectural delay slot and decides which address is fetched next. On each executed instruction (`step` high) it looks at the instruction word, the current PC and the two source-register values. It reports the next fetch address and any request to write a return address into the register file. It also flags when the program has finished.

A taken branch or jump does not redirect at once. The instruction after it (the delay slot) always runs first. The target is held in a pending register and is used as `next_pc` while that slot instruction executes. A jump through a register that holds zero ends the program: `halt` rises once the delay slot has executed and then stays high. After that the unit ignores further steps.

Top module: `npc_unit`

## Requirements
- R1: After reset nothing is pending, `halt` is 0 and `redirect` is 0. For a non-control instruction, `next_pc` equals `pc + 4`.
- R2: A non-control instruction, or any unknown opcode, causes no link write and no redirect. Opcode 0x01 with an rt field (bits 20:16) other than 0x00, 0x01, 0x10 or 0x11 also counts as non-control. In all these cases `next_pc` stays `pc + 4` on the following step.
- R3: Delay slot. While a taken branch or jump executes, `next_pc` is `pc + 4`. While the next stepped instruction executes, `redirect` is 1 and `next_pc` is the target. On the step after that, the pending state is cleared unless that instruction is itself a taken transfer.
- R4: Opcode 0x04 is taken when rs equals rt, and opcode 0x05 when they differ. The branch target is `pc + 4` plus the sign-extended 16-bit immediate (bits 15:0) times 4.
- R5: The sign tests treat rs as two's-complement signed and use the R4 target. Opcode 0x06 is taken when rs <= 0 and opcode 0x07 when rs > 0. Opcode 0x01 with rt field 0x00 is taken when rs < 0, and with rt field 0x01 when rs >= 0.
- R6: Opcode 0x01 with rt field 0x10 (less than zero) or 0x11 (greater or equal zero) branches as in R5. It also requests a link write of `pc + 8` to register 31, whether or not the branch is taken.
- R7: Opcode 0x02 and 0x03 always jump to the top 4 bits of `pc + 4`, followed by the 26-bit index (bits 25:0), followed by two zero bits. Opcode 0x03 also links `pc + 8` into register 31.
- R8: Opcode 0 with function (bits 5:0) 0x08 always jumps to rs. Function 0x09 does the same and also links `pc + 8` into the register named by bits 15:11.
- R9: A register jump whose rs is zero makes `halt` rise at the clock edge that ends the delay-slot step, not earlier. `halt` then stays 1 until reset. While it is high, `next_pc` equals `pc`, `redirect` is 0 and no link write is requested.
- R10: With `step` low, no link write is requested and the pending state does not change. A redirect that is waiting is still delivered on the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | The presented instruction executes this cycle |
| instr | input | 32 | Instruction word at `pc` |
| pc | input | 32 | Address of the presented instruction |
| rs_val | input | 32 | Value of register rs |
| rt_val | input | 32 | Value of register rt |
| next_pc | output | 32 | Address to fetch after this instruction |
| redirect | output | 1 | `next_pc` is a pending target (delay slot executing) |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Destination register of the link write |
| link_addr | output | 32 | Return address (`pc + 8`) |
| halt | output | 1 | Program has ended |

## Verification
A wrong pending register shows up as a missing or spurious `redirect`, or as a wrong `next_pc`. This happens exactly one step after the branch, in the delay-slot cycle, so every case checks both the branch step and the slot step. A wrong taken decision or target arithmetic is visible in that same slot cycle. A halt state that is set too early or not held shows at the edge ending the slot and on every later step, as link writes or redirects that should have stopped.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int NPC_W = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_JUMP    = 6'h02;
  localparam logic [5:0] OP_JLINK   = 6'h03;
  localparam logic [5:0] OP_EQ      = 6'h04;
  localparam logic [5:0] OP_NE      = 6'h05;
  localparam logic [5:0] OP_LEZ     = 6'h06;
  localparam logic [5:0] OP_GTZ     = 6'h07;

  localparam logic [4:0] RI_LTZ     = 5'h00;
  localparam logic [4:0] RI_GEZ     = 5'h01;
  localparam logic [4:0] RI_LTZ_LNK = 5'h10;
  localparam logic [4:0] RI_GEZ_LNK = 5'h11;

  localparam logic [5:0] FN_JREG    = 6'h08;
  localparam logic [5:0] FN_JREG_LK = 6'h09;

  localparam logic [4:0] RET_REG    = 5'd31;

  typedef enum logic [3:0] {
    K_NONE, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ, K_ABS, K_REG
  } ctrl_kind_e;

  typedef struct packed {
    ctrl_kind_e  kind;
    logic        link;
    logic [4:0]  link_idx;
    logic [15:0] imm;
    logic [25:0] index;
  } ctrl_dec_t;

  function automatic logic [NPC_W-1:0] seq_addr(input logic [NPC_W-1:0] a);
    return a + NPC_W'(4);
  endfunction

  function automatic logic [NPC_W-1:0] rel_target(input logic [NPC_W-1:0] a,
                                                  input logic [15:0] off);
    logic [NPC_W-1:0] disp;
    disp = {{(NPC_W-18){off[15]}}, off, 2'b00};
    return seq_addr(a) + disp;
  endfunction

  function automatic logic [NPC_W-1:0] abs_target(input logic [NPC_W-1:0] a,
                                                  input logic [25:0] idx);
    logic [NPC_W-1:0] s;
    s = seq_addr(a);
    return {s[NPC_W-1:28], idx, 2'b00};
  endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output ctrl_dec_t          dec
);

  localparam int OP_LSB = INSTR_W - 6;

  logic [5:0] opcode;
  logic [4:0] rt_f;
  logic [4:0] rd_f;
  logic [5:0] fn_f;

  assign opcode = instr[INSTR_W-1:OP_LSB];
  assign rt_f   = instr[20:16];
  assign rd_f   = instr[15:11];
  assign fn_f   = instr[5:0];

  always_comb begin
    dec          = '0;
    dec.kind     = K_NONE;
    dec.imm      = instr[15:0];
    dec.index    = instr[25:0];
    dec.link_idx = RET_REG;
    unique case (opcode)
      OP_EQ:    dec.kind = K_EQ;
      OP_NE:    dec.kind = K_NE;
      OP_LEZ:   dec.kind = K_LEZ;
      OP_GTZ:   dec.kind = K_GTZ;
      OP_JUMP:  dec.kind = K_ABS;
      OP_JLINK: begin
        dec.kind = K_ABS;
        dec.link = 1'b1;
      end
      OP_REGIMM: begin
        unique case (rt_f)
          RI_LTZ: dec.kind = K_LTZ;
          RI_GEZ: dec.kind = K_GEZ;
          RI_LTZ_LNK: begin
            dec.kind = K_LTZ;
            dec.link = 1'b1;
          end
          RI_GEZ_LNK: begin
            dec.kind = K_GEZ;
            dec.link = 1'b1;
          end
          default: dec.kind = K_NONE;
        endcase
      end
      OP_SPECIAL: begin
        if (fn_f == FN_JREG) begin
          dec.kind = K_REG;
        end else if (fn_f == FN_JREG_LK) begin
          dec.kind     = K_REG;
          dec.link     = 1'b1;
          dec.link_idx = rd_f;
        end
      end
      default: dec.kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrl_dec_t          dec,
  input  logic [DATA_W-1:0]  pc,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  output logic               taken,
  output logic [DATA_W-1:0]  target,
  output logic               end_req,
  output logic               link_req,
  output logic [4:0]         link_idx,
  output logic [DATA_W-1:0]  link_addr
);

  logic rs_neg;
  logic rs_zero;
  logic ops_equal;

  assign rs_neg    = rs_val[DATA_W-1];
  assign rs_zero   = (rs_val == '0);
  assign ops_equal = (rs_val == rt_val);

  always_comb begin
    taken  = 1'b0;
    target = rel_target(pc, dec.imm);
    unique case (dec.kind)
      K_EQ:  taken = ops_equal;
      K_NE:  taken = !ops_equal;
      K_LEZ: taken = rs_neg || rs_zero;
      K_GTZ: taken = !rs_neg && !rs_zero;
      K_LTZ: taken = rs_neg;
      K_GEZ: taken = !rs_neg;
      K_ABS: begin
        taken  = 1'b1;
        target = abs_target(pc, dec.index);
      end
      K_REG: begin
        taken  = 1'b1;
        target = rs_val;
      end
      default: taken = 1'b0;
    endcase
  end

  assign end_req   = (dec.kind == K_REG) && rs_zero;
  assign link_req  = dec.link;
  assign link_idx  = dec.link_idx;
  assign link_addr = seq_addr(seq_addr(pc));

endmodule

// File: rtl/npc_pending.sv
module npc_pending #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              taken,
  input  logic [DATA_W-1:0] target,
  input  logic              end_req,
  output logic              pend_q,
  output logic [DATA_W-1:0] tgt_q,
  output logic              halted_q
);

  logic end_pend_q;
  logic accept;
  logic slot_done;

  assign accept    = step && !halted_q;
  assign slot_done = accept && pend_q && end_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      tgt_q      <= '0;
      end_pend_q <= 1'b0;
      halted_q   <= 1'b0;
    end else begin
      if (accept) begin
        pend_q     <= taken;
        tgt_q      <= target;
        end_pend_q <= taken && end_req;
      end
      if (slot_done) halted_q <= 1'b1;
    end
  end

  a_r3_taken_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !halted_q && taken) |=> pend_q);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> ($stable(pend_q) && $stable(tgt_q)));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q);

  a_r9_halt_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_q) |-> $past(pend_q && step));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] next_pc,
  output logic              redirect,
  output logic              link_we,
  output logic [4:0]        link_idx,
  output logic [DATA_W-1:0] link_addr,
  output logic              halt
);

  ctrl_dec_t         dec;
  logic              taken;
  logic [DATA_W-1:0] target;
  logic              end_req;
  logic              link_req;
  logic              pend_q;
  logic [DATA_W-1:0] tgt_q;
  logic              halted_q;

  npc_decode #(.INSTR_W(32)) u_decode (
    .instr (instr),
    .dec   (dec)
  );

  npc_resolve #(.DATA_W(DATA_W)) u_resolve (
    .dec       (dec),
    .pc        (pc),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .taken     (taken),
    .target    (target),
    .end_req   (end_req),
    .link_req  (link_req),
    .link_idx  (link_idx),
    .link_addr (link_addr)
  );

  npc_pending #(.DATA_W(DATA_W)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .taken    (taken),
    .target   (target),
    .end_req  (end_req),
    .pend_q   (pend_q),
    .tgt_q    (tgt_q),
    .halted_q (halted_q)
  );

  assign halt     = halted_q;
  assign redirect = pend_q && !halted_q;
  assign link_we  = step && !halted_q && link_req;
  assign next_pc  = halted_q ? pc : (pend_q ? tgt_q : seq_addr(pc));

  a_r9_no_link_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!link_we && !redirect));

  a_r3_redirect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && step && !taken) |=> !redirect);

endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step;
  logic [31:0] instr, pc, rs_val, rt_val;
  logic [31:0] next_pc, link_addr;
  logic        redirect, link_we, halt;
  logic [4:0]  link_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .instr(instr), .pc(pc),
    .rs_val(rs_val), .rt_val(rt_val), .next_pc(next_pc), .redirect(redirect),
    .link_we(link_we), .link_idx(link_idx), .link_addr(link_addr), .halt(halt)
  );

  localparam logic [31:0] NOP = 32'h0000_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    instr = i; pc = p; rs_val = a; rt_val = b; step = s;
    #1;
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // Independent behavioural model of the requirements
  function automatic void model(input logic [31:0] ins, input logic [31:0] p,
                                input logic [31:0] a, input logic [31:0] b,
                                output logic tk, output logic [31:0] tg,
                                output logic lw, output logic [4:0] li);
    logic [31:0] p4;
    int sa;
    p4 = p + 32'd4;
    sa = $signed(a);
    tk = 0; lw = 0; li = 5'd31;
    tg = p4 + ($signed({{16{ins[15]}}, ins[15:0]}) * 4);
    case (ins[31:26])
      6'h04: tk = (a == b);
      6'h05: tk = (a != b);
      6'h06: tk = (sa <= 0);
      6'h07: tk = (sa > 0);
      6'h01: case (ins[20:16])
               5'h00: tk = (sa < 0);
               5'h01: tk = (sa >= 0);
               5'h10: begin tk = (sa < 0); lw = 1; end
               5'h11: begin tk = (sa >= 0); lw = 1; end
               default: tk = 0;
             endcase
      6'h02: begin tk = 1; tg = {p4[31:28], ins[25:0], 2'b00}; end
      6'h03: begin tk = 1; lw = 1; tg = {p4[31:28], ins[25:0], 2'b00}; end
      6'h00: if (ins[5:0] == 6'h08) begin tk = 1; tg = a; end
             else if (ins[5:0] == 6'h09) begin tk = 1; tg = a; lw = 1; li = ins[15:11]; end
      default: tk = 0;
    endcase
  endfunction

  // One control instruction followed by a NOP in its delay slot
  task automatic run_case(input string tag, input logic [31:0] ins, input logic [31:0] p,
                          input logic [31:0] a, input logic [31:0] b);
    logic tk, lw;
    logic [31:0] tg;
    logic [4:0] li;
    model(ins, p, a, b, tk, tg, lw, li);
    drive(ins, p, a, b, 1'b1);
    chk({tag, " R3 branch-step next_pc"}, next_pc, p + 32'd4);
    chk({tag, " R6 link_we"}, {31'd0, link_we}, {31'd0, lw});
    if (lw) begin
      chk({tag, " R7 link_idx"}, {27'd0, link_idx}, {27'd0, li});
      chk({tag, " R8 link_addr"}, link_addr, p + 32'd8);
    end
    drive(NOP, p + 32'd4, 32'd0, 32'd0, 1'b1);
    chk({tag, " R3 slot redirect"}, {31'd0, redirect}, {31'd0, tk});
    chk({tag, " R4 slot next_pc"}, next_pc, tk ? tg : p + 32'd8);
    chk({tag, " R2 slot no link"}, {31'd0, link_we}, 32'd0);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] vals[6];
    logic [15:0] offs[3];
    logic [31:0] base;
    vals[0] = 32'd0; vals[1] = 32'd1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'd5;
    offs[0] = 16'd3; offs[1] = 16'hFFFF; offs[2] = 16'h8000;
    base = 32'hBFC0_0100;

    rst_n = 0; step = 0; instr = NOP; pc = base; rs_val = 0; rt_val = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    drive(NOP, base, 0, 0, 1'b1);
    chk("R1 reset redirect", {31'd0, redirect}, 32'd0);
    chk("R1 reset halt", {31'd0, halt}, 32'd0);
    chk("R1 sequential next_pc", next_pc, base + 32'd4);

    // R4 equality branches across operand pairs and offsets
    for (int o = 0; o < 3; o++)
      for (int x = 0; x < 6; x++)
        for (int y = 0; y < 6; y++) begin
          run_case("R4 eq", mk_i(6'h04, 5'd4, 5'd5, offs[o]), base, vals[x], vals[y]);
          run_case("R4 ne", mk_i(6'h05, 5'd4, 5'd5, offs[o]), base, vals[x], vals[y]);
        end

    // R5 / R6 sign tests and link variants
    for (int o = 0; o < 3; o++)
      for (int x = 0; x < 6; x++) begin
        run_case("R5 lez", mk_i(6'h06, 5'd4, 5'd0, offs[o]), base, vals[x], 32'd5);
        run_case("R5 gtz", mk_i(6'h07, 5'd4, 5'd0, offs[o]), base, vals[x], 32'd5);
        run_case("R5 ltz", mk_i(6'h01, 5'd4, 5'h00, offs[o]), base, vals[x], 32'd5);
        run_case("R5 gez", mk_i(6'h01, 5'd4, 5'h01, offs[o]), base, vals[x], 32'd5);
        run_case("R6 ltzl", mk_i(6'h01, 5'd4, 5'h10, offs[o]), base, vals[x], 32'd5);
        run_case("R6 gezl", mk_i(6'h01, 5'd4, 5'h11, offs[o]), base, vals[x], 32'd5);
        run_case("R2 regimm-unk", mk_i(6'h01, 5'd4, 5'h02, offs[o]), base, vals[x], 32'd5);
        run_case("R2 other-op", mk_i(6'h09, 5'd4, 5'd2, offs[o]), base, vals[x], 32'd5);
      end

    // R7 absolute jumps, including a top-nibble change at pc+4
    run_case("R7 j", {6'h02, 26'h000_0004}, base, 0, 0);
    run_case("R7 jal", {6'h03, 26'h3FF_FFFF}, base, 0, 0);
    run_case("R7 j nibble", {6'h02, 26'h123_4567}, 32'h3FFF_FFFC, 0, 0);
    run_case("R7 jal nibble", {6'h03, 26'h000_0010}, 32'h3FFF_FFFC, 0, 0);

    // R8 register jumps with nonzero targets
    for (int x = 1; x < 6; x++) begin
      run_case("R8 jr", {6'h00, 5'd5, 5'd0, 5'd0, 5'd0, 6'h08}, base, vals[x], 0);
      run_case("R8 jalr", {6'h00, 5'd5, 5'd0, 5'(x + 2), 5'd0, 6'h09}, base, vals[x], 0);
    end

    // R10 idle steps keep a pending redirect
    drive(mk_i(6'h04, 5'd4, 5'd5, 16'd3), base, 7, 7, 1'b1);
    drive({6'h03, 26'h10}, base + 32'd4, 0, 0, 1'b0);
    chk("R10 idle no link", {31'd0, link_we}, 32'd0);
    chk("R10 idle pending kept", {31'd0, redirect}, 32'd1);
    drive(NOP, base + 32'd4, 0, 0, 1'b0);
    chk("R10 idle target kept", next_pc, base + 32'd4 + 32'd12);
    drive(NOP, base + 32'd4, 0, 0, 1'b1);
    chk("R10 slot redirect", {31'd0, redirect}, 32'd1);
    drive(NOP, base + 32'd20, 0, 0, 1'b1);
    chk("R3 pending cleared", {31'd0, redirect}, 32'd0);
    chk("R3 after slot next_pc", next_pc, base + 32'd24);

    // R9 termination through a zero register
    drive({6'h00, 5'd0, 5'd0, 5'd0, 5'd0, 6'h08}, base, 0, 0, 1'b1);
    chk("R9 halt not yet", {31'd0, halt}, 32'd0);
    drive(NOP, base + 32'd4, 0, 0, 1'b1);
    chk("R9 slot halt low", {31'd0, halt}, 32'd0);
    chk("R9 slot next_pc", next_pc, 32'd0);
    drive({6'h03, 26'h10}, 32'h0, 0, 0, 1'b1);
    chk("R9 halt raised", {31'd0, halt}, 32'd1);
    chk("R9 no link when halted", {31'd0, link_we}, 32'd0);
    chk("R9 no redirect when halted", {31'd0, redirect}, 32'd0);
    chk("R9 next_pc holds", next_pc, 32'h0);
    drive(NOP, 32'h40, 0, 0, 1'b1);
    chk("R9 halt sticky", {31'd0, halt}, 32'd1);

    rst_n = 0;
    drive(NOP, base, 0, 0, 1'b0);
    drive(NOP, base, 0, 0, 1'b0);
    rst_n = 1;
    drive(NOP, base, 0, 0, 1'b1);
    chk("R1 reset clears halt", {31'd0, halt}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule